// File: doc/BRIEF.md
# LCD Scanline Mode Sequencer

This block is the per-dot timing engine of a 160x144 LCD controller. Each dot-clock enable moves a dot counter forward. A four-state machine steps every visible line through sprite-attribute search, pixel transfer and horizontal blank. Ten extra lines form the vertical blank period. The block keeps the current line number and compares it with a software-programmed compare value. It also assembles a status byte that joins software-writable event enables with live read-only bits: the mode and the compare-match flag.

The block feeds an interrupt controller with two single-cycle request pulses. The first is a dedicated vertical-blank request. The second is a status request, raised by whichever events the status enables select: entry to horizontal blank, entry to vertical blank, entry to attribute search, or the line counter changing to the compare value. Software reaches the status byte, the line counter and the compare register through a small byte-wide port with a 2-bit register select. The controller's display-enable bit holds the sequencer in its reset position while it is low.

The state machine has four states. `MODE_OAM` (code 2) moves to `MODE_XFER` (code 3) after its dots are spent. `MODE_XFER` moves to `MODE_HBLANK` (code 0) at the end of pixel transfer. `MODE_HBLANK` moves at the end of the line either back to `MODE_OAM` with the line counter incremented, or to `MODE_VBLANK` (code 1) when the new line is the first non-visible line. `MODE_VBLANK` counts lines and returns to `MODE_OAM` on line 0 after the last line.

Top module: `lcd_mode_seq`

## Requirements
- R1: After reset the sequencer is on line 0 in mode 2 with the dot counter cleared. The status and compare registers are zero, so a status read returns 0x06.
- R2: Modes are encoded as horizontal blank = 0, vertical blank = 1, attribute search = 2 and pixel transfer = 3. A visible line spends 80 dots in mode 2, then 172 dots in mode 3, then 204 dots in mode 0.
- R3: At the end of horizontal blank the line counter increments. Lines 0 to 143 are visible lines and return to mode 2. Reaching line 144 enters mode 1.
- R4: In mode 1 the line counter advances every 456 dots. When line 153 ends, the counter wraps to 0 and the mode returns to 2. The line counter never exceeds 153.
- R5: A status read returns the stored bits [7:3], bit 2 set when the line counter equals the compare register, and the mode in bits [1:0]. A status write changes only bits [7:3].
- R6: The line counter is read-only. A write to it leaves its value unchanged.
- R7: `irq_vblank` is a one-cycle pulse in the first cycle of mode 1. It fires once per frame, regardless of the status enables.
- R8: `irq_stat` pulses for one cycle on entry to mode 0 when status bit 3 is set, on entry to mode 1 when bit 4 is set, and on entry to mode 2 when bit 5 is set. With an enable clear, the matching entry raises no pulse. Events in the same cycle give one pulse.
- R9: With status bit 6 set, `irq_stat` pulses once, in the cycle the line counter changes to the compare value. It does not pulse again while the value stays equal.
- R10: With `dot_en` low, mode and line are frozen. With `lcd_on` low, the sequencer sits on line 0 in mode 2 with no requests, and it restarts the line from dot 0 when `lcd_on` rises again.
- R11: Register select codes are 0 = status, 1 = line counter, 2 = compare and 3 = unused. Code 3 reads as 0x00 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dot_en | input | 1 | Dot-clock enable; one dot per high cycle |
| lcd_on | input | 1 | Display-enable bit from the control register |
| reg_sel | input | 2 | Register select (0 status, 1 line, 2 compare) |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register (combinational) |
| mode | output | 2 | Current display mode |
| irq_vblank | output | 1 | Vertical-blank request pulse |
| irq_stat | output | 1 | Status event request pulse |

## Verification
The bench times every mode boundary of the first visible lines, the last visible line and the frame wrap to the exact dot. An off-by-one in any phase length moves a transition by a cycle and shows up as the wrong mode or line at that sample. It counts status pulses over a whole frame with every enable set. A design that lets a coincident compare match and attribute-search entry make two pulses, or that raises a pulse on reset entry, gives the wrong total. The compare test checks that the match pulse appears once, on the exact change cycle, and not while the value stays equal. The bench also checks that writes to the line counter and to the status bits [2:0] are ignored when read back, and that the display-enable bit restarts the line from dot zero.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

    typedef enum logic [1:0] {
        MODE_HBLANK = 2'd0,
        MODE_VBLANK = 2'd1,
        MODE_OAM    = 2'd2,
        MODE_XFER   = 2'd3
    } lcd_mode_e;

    localparam logic [1:0] SEL_STAT = 2'd0;
    localparam logic [1:0] SEL_LY   = 2'd1;
    localparam logic [1:0] SEL_LYC  = 2'd2;

endpackage

// File: rtl/lcd_dot_timer.sv
module lcd_dot_timer #(
    parameter int LINE_DOTS = 456,
    parameter int OAM_DOTS  = 80,
    parameter int XFER_DOTS = 172,
    localparam int DOT_W    = $clog2(LINE_DOTS)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic dot_en,
    output logic oam_done,
    output logic xfer_done,
    output logic line_done
);

    logic [DOT_W-1:0] dot_q;
    logic             step;

    assign step = run && dot_en;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            dot_q <= '0;
        end else if (dot_en) begin
            if (dot_q == DOT_W'(LINE_DOTS - 1)) begin
                dot_q <= '0;
            end else begin
                dot_q <= dot_q + DOT_W'(1);
            end
        end
    end

    assign oam_done  = step && (dot_q == DOT_W'(OAM_DOTS - 1));
    assign xfer_done = step && (dot_q == DOT_W'(OAM_DOTS + XFER_DOTS - 1));
    assign line_done = step && (dot_q == DOT_W'(LINE_DOTS - 1));

endmodule

// File: rtl/lcd_mode_fsm.sv
module lcd_mode_fsm
    import lcd_seq_pkg::*;
#(
    parameter int VIS_LINES   = 144,
    parameter int TOTAL_LINES = 154,
    localparam int LINE_W     = $clog2(TOTAL_LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              oam_done,
    input  logic              xfer_done,
    input  logic              line_done,
    output lcd_mode_e         mode,
    output logic [LINE_W-1:0] ly,
    output logic              ev_hblank,
    output logic              ev_vblank,
    output logic              ev_oam,
    output logic              ly_changed
);

    lcd_mode_e         state_q, state_n;
    logic [LINE_W-1:0] ly_q, ly_n;

    always_comb begin
        state_n = state_q;
        ly_n    = ly_q;
        unique case (state_q)
            MODE_OAM: begin
                if (oam_done) state_n = MODE_XFER;
            end
            MODE_XFER: begin
                if (xfer_done) state_n = MODE_HBLANK;
            end
            MODE_HBLANK: begin
                if (line_done) begin
                    ly_n = ly_q + LINE_W'(1);
                    if (ly_q == LINE_W'(VIS_LINES - 1)) begin
                        state_n = MODE_VBLANK;
                    end else begin
                        state_n = MODE_OAM;
                    end
                end
            end
            MODE_VBLANK: begin
                if (line_done) begin
                    if (ly_q == LINE_W'(TOTAL_LINES - 1)) begin
                        ly_n    = '0;
                        state_n = MODE_OAM;
                    end else begin
                        ly_n = ly_q + LINE_W'(1);
                    end
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            state_q <= MODE_OAM;
            ly_q    <= '0;
        end else begin
            state_q <= state_n;
            ly_q    <= ly_n;
        end
    end

    // entry-event outputs
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            ev_hblank  <= 1'b0;
            ev_vblank  <= 1'b0;
            ev_oam     <= 1'b0;
            ly_changed <= 1'b0;
        end else begin
            ev_hblank  <= (state_n != state_q) && (state_n == MODE_HBLANK);
            ev_vblank  <= (state_n != state_q) && (state_n == MODE_VBLANK);
            ev_oam     <= (state_n != state_q) && (state_n == MODE_OAM);
            ly_changed <= (ly_n != ly_q);
        end
    end

    assign mode = state_q;
    assign ly   = ly_q;

endmodule

// File: rtl/lcd_stat_regs.sv
module lcd_stat_regs
    import lcd_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [1:0] sel,
    input  logic [7:0] wdata,
    input  lcd_mode_e  mode,
    input  logic [7:0] ly,
    input  logic       ev_hblank,
    input  logic       ev_vblank,
    input  logic       ev_oam,
    input  logic       ly_changed,
    output logic [7:0] rdata,
    output logic       irq_vblank,
    output logic       irq_stat
);

    logic [4:0] stat_hi_q;   // status bits [7:3]
    logic [7:0] lyc_q;
    logic       coinc;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_hi_q <= '0;
            lyc_q     <= '0;
        end else if (wr_en) begin
            if (sel == SEL_STAT) stat_hi_q <= wdata[7:3];
            if (sel == SEL_LYC)  lyc_q     <= wdata;
        end
    end

    assign coinc = (ly == lyc_q);

    always_comb begin
        unique case (sel)
            SEL_STAT: rdata = {stat_hi_q, coinc, mode};
            SEL_LY:   rdata = ly;
            SEL_LYC:  rdata = lyc_q;
            default:  rdata = 8'h00;
        endcase
    end

    // stat_hi_q[0..3] are status bits 3..6
    assign irq_stat = (ev_hblank && stat_hi_q[0]) ||
                      (ev_vblank && stat_hi_q[1]) ||
                      (ev_oam    && stat_hi_q[2]) ||
                      (ly_changed && coinc && stat_hi_q[3]);
    assign irq_vblank = ev_vblank;

endmodule

// File: rtl/lcd_mode_seq.sv
module lcd_mode_seq
    import lcd_seq_pkg::*;
#(
    parameter int LINE_DOTS   = 456,
    parameter int OAM_DOTS    = 80,
    parameter int XFER_DOTS   = 172,
    parameter int VIS_LINES   = 144,
    parameter int TOTAL_LINES = 154,
    localparam int LINE_W     = $clog2(TOTAL_LINES)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dot_en,
    input  logic       lcd_on,
    input  logic [1:0] reg_sel,
    input  logic       reg_wr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic [1:0] mode,
    output logic       irq_vblank,
    output logic       irq_stat
);

    logic              oam_done, xfer_done, line_done;
    logic              ev_hblank, ev_vblank, ev_oam, ly_changed;
    lcd_mode_e         mode_w;
    logic [LINE_W-1:0] ly_w;
    logic [7:0]        ly_q;

    lcd_dot_timer #(
        .LINE_DOTS (LINE_DOTS),
        .OAM_DOTS  (OAM_DOTS),
        .XFER_DOTS (XFER_DOTS)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (lcd_on),
        .dot_en    (dot_en),
        .oam_done  (oam_done),
        .xfer_done (xfer_done),
        .line_done (line_done)
    );

    lcd_mode_fsm #(
        .VIS_LINES   (VIS_LINES),
        .TOTAL_LINES (TOTAL_LINES)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (lcd_on),
        .oam_done   (oam_done),
        .xfer_done  (xfer_done),
        .line_done  (line_done),
        .mode       (mode_w),
        .ly         (ly_w),
        .ev_hblank  (ev_hblank),
        .ev_vblank  (ev_vblank),
        .ev_oam     (ev_oam),
        .ly_changed (ly_changed)
    );

    assign ly_q = 8'(ly_w);

    lcd_stat_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (reg_wr),
        .sel        (reg_sel),
        .wdata      (reg_wdata),
        .mode       (mode_w),
        .ly         (ly_q),
        .ev_hblank  (ev_hblank),
        .ev_vblank  (ev_vblank),
        .ev_oam     (ev_oam),
        .ly_changed (ly_changed),
        .rdata      (reg_rdata),
        .irq_vblank (irq_vblank),
        .irq_stat   (irq_stat)
    );

    assign mode = mode_w;

endmodule

// File: rtl/lcd_mode_seq_chk.sv
module lcd_mode_seq_chk #(
    parameter int VIS_LINES   = 144,
    parameter int TOTAL_LINES = 154
) (
    input logic       clk,
    input logic       rst_n,
    input logic       dot_en,
    input logic       lcd_on,
    input logic       reg_wr,
    input logic [1:0] reg_sel,
    input logic [1:0] mode,
    input logic [7:0] ly,
    input logic       irq_vblank,
    input logic       irq_stat
);

    p_ly_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ly <= 8'(TOTAL_LINES - 1));

    p_vblank_lines_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd1) |-> (ly >= 8'(VIS_LINES)));

    p_visible_lines_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ly >= 8'(VIS_LINES)) |-> (mode == 2'd1));

    p_vb_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_vblank |=> !irq_vblank);

    p_vb_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_vblank |-> (mode == 2'd1 && ly == 8'(VIS_LINES)));

    p_stat_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_stat |=> !irq_stat);

    p_ly_readonly_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == 2'd1 && lcd_on && !dot_en) |=> $stable(ly));

    p_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (lcd_on && !dot_en) |=> ($stable(mode) && $stable(ly)));

    p_off_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !lcd_on |=> (mode == 2'd2 && ly == 8'd0 && !irq_vblank && !irq_stat));

endmodule

bind lcd_mode_seq lcd_mode_seq_chk #(
    .VIS_LINES   (VIS_LINES),
    .TOTAL_LINES (TOTAL_LINES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dot_en     (dot_en),
    .lcd_on     (lcd_on),
    .reg_wr     (reg_wr),
    .reg_sel    (reg_sel),
    .mode       (mode),
    .ly         (ly_q),
    .irq_vblank (irq_vblank),
    .irq_stat   (irq_stat)
);

// File: tb/test_lcd_mode_seq.sv
module test_lcd_mode_seq;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dot_en = 1'b0;
    logic       lcd_on = 1'b1;
    logic [1:0] reg_sel = 2'd0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic [1:0] mode;
    logic       irq_vblank, irq_stat;

    int errors = 0;
    int checks = 0;
    int vb_cnt = 0;
    int st_cnt = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    lcd_mode_seq i_lcd_mode_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .dot_en     (dot_en),
        .lcd_on     (lcd_on),
        .reg_sel    (reg_sel),
        .reg_wr     (reg_wr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .mode       (mode),
        .irq_vblank (irq_vblank),
        .irq_stat   (irq_stat)
    );

    // pulse counters, sampled just after each rising edge
    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            vb_cnt = vb_cnt + int'(irq_vblank);
            st_cnt = st_cnt + int'(irq_stat);
        end
    end

    typedef struct packed {
        logic [31:0] adv;
        logic [1:0]  mode;
        logic [7:0]  ly;
        logic        vb;
        logic        st;
    } vec_t;

    // STAT = 0x78 (all enables), LYC = 2; adv = rising edges before sample
    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{32'd79,    2'd2, 8'd0,   1'b0, 1'b0},
        '{32'd1,     2'd3, 8'd0,   1'b0, 1'b0},
        '{32'd171,   2'd3, 8'd0,   1'b0, 1'b0},
        '{32'd1,     2'd0, 8'd0,   1'b0, 1'b1},
        '{32'd203,   2'd0, 8'd0,   1'b0, 1'b0},
        '{32'd1,     2'd2, 8'd1,   1'b0, 1'b1},
        '{32'd456,   2'd2, 8'd2,   1'b0, 1'b1},
        '{32'd1,     2'd2, 8'd2,   1'b0, 1'b0},
        '{32'd64750, 2'd0, 8'd143, 1'b0, 1'b0},
        '{32'd1,     2'd1, 8'd144, 1'b1, 1'b1},
        '{32'd1,     2'd1, 8'd144, 1'b0, 1'b0},
        '{32'd4558,  2'd1, 8'd153, 1'b0, 1'b0},
        '{32'd1,     2'd2, 8'd0,   1'b0, 1'b1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] data);
        reg_sel   = sel;
        reg_wdata = data;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [7:0] data);
        reg_sel = sel;
        #1;
        data = reg_rdata;
    endtask

    task automatic do_reset();
        rst_n  = 1'b0;
        dot_en = 1'b0;
        lcd_on = 1'b1;
        step(3);
        rst_n = 1'b1;
    endtask

    initial begin
        #800000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        int base_vb, base_st;
        @(negedge clk);
        do_reset();

        // R1 reset state
        chk("R1 mode", 32'(mode), 32'd2);
        rd(2'd1, d); chk("R1 ly", 32'(d), 32'd0);
        rd(2'd0, d); chk("R1 status", 32'(d), 32'h06);
        chk("R1 no irq", 32'({irq_vblank, irq_stat}), 32'd0);

        // R5 status write keeps low bits live; R10 frozen while dot_en low
        wr(2'd0, 8'hFF);
        rd(2'd0, d); chk("R5 status write", 32'(d), 32'hFE);
        chk("R10 frozen mode", 32'(mode), 32'd2);
        // R6 line counter write ignored
        wr(2'd1, 8'h55);
        rd(2'd1, d); chk("R6 ly readonly", 32'(d), 32'd0);
        // R11 unused select
        wr(2'd3, 8'hA5);
        rd(2'd3, d); chk("R11 unused reads zero", 32'(d), 32'd0);
        wr(2'd2, 8'h03);
        rd(2'd2, d); chk("R11 compare readback", 32'(d), 32'h03);
        rd(2'd0, d); chk("R5 coinc clear", 32'(d), 32'hFA);

        // full frame walk: R2 R3 R4 R7 R8
        wr(2'd0, 8'h78);
        wr(2'd2, 8'h02);
        reg_sel = 2'd1;
        base_vb = vb_cnt;
        base_st = st_cnt;
        dot_en  = 1'b1;
        for (int i = 0; i < NV; i++) begin
            step(int'(VECS[i].adv));
            #1;
            chk("R2 mode", 32'(mode), 32'(VECS[i].mode));
            chk("R3 R4 line", 32'(reg_rdata), 32'(VECS[i].ly));
            chk("R7 vblank irq", 32'(irq_vblank), 32'(VECS[i].vb));
            chk("R8 R9 status irq", 32'(irq_stat), 32'(VECS[i].st));
        end
        chk("R7 vblank pulses per frame", 32'(vb_cnt - base_vb), 32'd1);
        chk("R8 status pulses per frame", 32'(st_cnt - base_st), 32'd289);

        // R9 compare-only enable
        step(1);
        do_reset();
        wr(2'd0, 8'h40);
        wr(2'd2, 8'h01);
        rd(2'd0, d); chk("R5 status with enable", 32'(d), 32'h42);
        reg_sel = 2'd1;
        base_st = st_cnt;
        dot_en  = 1'b1;
        step(455);
        #1;
        chk("R8 hblank entry disabled", 32'(st_cnt - base_st), 32'd0);
        step(1);
        #1;
        chk("R9 match pulse", 32'(irq_stat), 32'd1);
        chk("R9 line", 32'(reg_rdata), 32'd1);
        rd(2'd0, d); chk("R5 coinc set", 32'(d), 32'h46);
        step(1);
        #1;
        chk("R9 single pulse", 32'(irq_stat), 32'd0);
        step(300);
        chk("R9 no repeat", 32'(st_cnt - base_st), 32'd1);

        // R10 display off / on
        lcd_on = 1'b0;
        step(1);
        reg_sel = 2'd1;
        #1;
        chk("R10 off line", 32'(reg_rdata), 32'd0);
        chk("R10 off mode", 32'(mode), 32'd2);
        step(100);
        #1;
        chk("R10 off still", 32'(mode), 32'd2);
        lcd_on = 1'b1;
        step(79);
        #1;
        chk("R10 restart oam", 32'(mode), 32'd2);
        step(1);
        #1;
        chk("R10 restart xfer", 32'(mode), 32'd3);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule